// File: doc/BRIEF.md
# Drive Status Packet and Command Decoder

This block is the byte-wide mailbox between a host processor and a disc drive controller. In one direction it builds a ten-byte status packet. The packet holds four 16-bit words, each stored high byte first: status, minute, second and frame. An extension byte follows them, and the packet closes with a 4-bit checksum. The packet is captured on a single-cycle export request, and the block can signal an interrupt when it is captured.

In the other direction the host fills a ten-byte command packet. Writing the last byte of that packet makes the block decode the opcode into a command code. For a table-of-contents query, the block also decodes a sub-query number. The sub-query result becomes the low byte of the status word sent in later packets. The host reads and writes everything through one byte-addressed port. The same port also holds a 16-bit fader level, a drive control byte and an interrupt mask.

Top module: `drv_mailbox`

## Requirements
- R1: After reset every readable byte is 0x00, except status byte 9, which reads 0x0F. cmd_valid and drv_irq are low, cmd_code and toc_sub are 0, and the internal query byte is 0x00.
- R2: In the cycle after export_req, status bytes 0..7 hold the status, minute, second and frame words, each with its high byte at the even address. Byte 8 holds drv_ext. These bytes do not change unless export_req is asserted.
- R3: Status byte 9 reads as the low nibble of the bitwise inverse of the 8-bit sum of bytes 0..8. Its upper nibble is 0.
- R4: The exported status word takes its high byte from drv_stat_hi and its low byte from the query byte.
- R5: An export leaves only bits 1:0 of the drive control byte (address 22). In the same cycle, the export overrides any host write to that byte.
- R6: drv_irq is high for the cycle after an export if bit 4 of the mask byte (address 23) is set. drv_irq is never high in any other cycle.
- R7: Addresses 10..19 hold command bytes 0..9 and can be read and written. Host writes to addresses 0..9 have no effect.
- R8: A write to address 19 produces a one-cycle cmd_valid pulse in the next cycle, decoded from the stored opcode at address 10. cmd_code and toc_sub hold their values until the next such write.
- R9: cmd_code encoding: opcodes 0x00, 0x01, 0x03, 0x04, 0x06, 0x07, 0x08, 0x09, 0x0A, 0x0C and 0x0D map to their low nibble. Every other opcode, except 0x02, maps to 0xF.
- R10: For opcode 0x02 with command byte 3 (address 13) in 0..5, cmd_code is 2, toc_sub equals byte 3, and the query byte becomes byte 3.
- R11: For opcode 0x02 with byte 3 greater than 5, cmd_code is 0, toc_sub is 0 and the query byte becomes 0x0F. Any other opcode leaves the query byte unchanged.
- R12: Address 20 holds fader bits 15:8 and address 21 holds fader bits 7:0; both bytes appear on fader_level. Addresses 24..31 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host byte write strobe |
| host_addr | input | 5 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (combinational) |
| export_req | input | 1 | Single-cycle status packet capture request |
| drv_stat_hi | input | 8 | High byte of the drive status word |
| drv_min | input | 16 | Minute word |
| drv_sec | input | 16 | Second word |
| drv_frm | input | 16 | Frame word |
| drv_ext | input | 8 | Extension byte |
| drv_irq | output | 1 | Status-export interrupt pulse |
| cmd_valid | output | 1 | Command decoded strobe |
| cmd_code | output | 4 | Decoded command code |
| toc_sub | output | 3 | Decoded table-of-contents sub-query |
| fader_level | output | 16 | Fader register value |
| drv_ctrl | output | 8 | Drive control register value |

## Verification
The assertions check several properties on every cycle. The status bytes move only on an export, and drv_irq appears only after an export with the mask bit set. cmd_valid follows only a write to the last command byte, and the decode outputs hold between strobes. The control byte is trimmed after each export, and the query byte matches toc_sub on every table-of-contents strobe. Some behaviour shows only in the bench's scenarios: the checksum value for arbitrary packets, the full opcode table, out-of-range sub-queries, the priority of an export over a simultaneous control write, and the fact that writes to the status area are ignored.

// File: rtl/drv_mbox_pkg.sv
// Shared constants, command codes and the packet checksum for the drive mailbox.
// Assumes a ten-byte packet and a 5-bit byte address space.
package drv_mbox_pkg;
    localparam int PKT_BYTES = 10;
    localparam int ADDR_W    = 5;
    localparam int IDX_W     = $clog2(PKT_BYTES);
    localparam int SUB_W     = 3;
    localparam logic [7:0] SUB_MAX = 8'd5;
    localparam logic [7:0] BAD_SUB_QUERY = 8'h0F;

    typedef enum logic [3:0] {
        OP_STATUS  = 4'h0,
        OP_STOP    = 4'h1,
        OP_TOC     = 4'h2,
        OP_READ    = 4'h3,
        OP_SEEK    = 4'h4,
        OP_PAUSE   = 4'h6,
        OP_RESUME  = 4'h7,
        OP_FWD     = 4'h8,
        OP_REW     = 4'h9,
        OP_RESTORE = 4'hA,
        OP_CLOSE   = 4'hC,
        OP_OPEN    = 4'hD,
        OP_UNKNOWN = 4'hF
    } drv_cmd_e;

    // Checksum byte: low nibble of the inverted sum of the first nine bytes.
    function automatic logic [7:0] pkt_checksum(input logic [PKT_BYTES-2:0][7:0] b);
        logic [7:0] s;
        s = 8'h00;
        for (int i = 0; i < PKT_BYTES - 1; i++) s = s + b[i];
        return 8'h0F & ~s;
    endfunction
endpackage

// File: rtl/drv_status_packer.sv
// Status packet builder: on export_req it captures the four 16-bit words
// (high byte first), the extension byte and the checksum, and pulses irq
// when irq_en is set. Assumes export_req lasts one cycle per export.
module drv_status_packer
    import drv_mbox_pkg::*;
#(
    parameter int NBYTES = PKT_BYTES,
    parameter int WORD_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   export_req,
    input  logic                   irq_en,
    input  logic [WORD_W-1:0]      stat_word,
    input  logic [WORD_W-1:0]      min_word,
    input  logic [WORD_W-1:0]      sec_word,
    input  logic [WORD_W-1:0]      frm_word,
    input  logic [7:0]             ext_byte,
    output logic [NBYTES-1:0][7:0] stat_bytes,
    output logic                   irq
);
    localparam int NWORDS = 4;
    localparam logic [NBYTES-1:0][7:0] RST_PKT = {8'h0F, {(NBYTES-1){8'h00}}};

    logic [NWORDS-1:0][WORD_W-1:0] words;
    logic [NBYTES-1:0][7:0]        nxt;

    assign words = {frm_word, sec_word, min_word, stat_word};

    // Lay out each word high byte first at consecutive even offsets.
    for (genvar gi = 0; gi < NWORDS; gi++) begin : g_word
        assign nxt[2*gi]   = words[gi][WORD_W-1:WORD_W-8];
        assign nxt[2*gi+1] = words[gi][7:0];
    end
    assign nxt[NBYTES-2] = ext_byte;
    assign nxt[NBYTES-1] = pkt_checksum(nxt[NBYTES-2:0]);

    // Packet register: capture the whole packet on an export.
    always_ff @(posedge clk) begin
        if (!rst_n)          stat_bytes <= RST_PKT;
        else if (export_req) stat_bytes <= nxt;
    end

    // Interrupt pulse: one cycle after an export with the enable set.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= export_req & irq_en;
    end

    assert_pkt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(export_req) |-> $stable(stat_bytes));
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(export_req) && $past(irq_en)));
endmodule

// File: rtl/drv_cmd_decoder.sv
// Command packet store and decoder: holds ten command bytes, and on a write
// to the last byte decodes the stored opcode and sub-query into registered
// outputs that stay put until the next such write. Also owns the query byte.
module drv_cmd_decoder
    import drv_mbox_pkg::*;
#(
    parameter int NBYTES = PKT_BYTES,
    parameter int IW     = IDX_W,
    parameter int SW     = SUB_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [IW-1:0]          wr_idx,
    input  logic [7:0]             wr_data,
    output logic [NBYTES-1:0][7:0] cmd_bytes,
    output logic                   cmd_valid,
    output logic [3:0]             cmd_code,
    output logic [SW-1:0]          toc_sub,
    output logic [7:0]             query_lo
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NBYTES - 1);
    localparam int OPC_IDX = 0;
    localparam int SUB_IDX = 3;

    logic       strobe;
    drv_cmd_e   dec_code, code_q;
    logic [SW-1:0] dec_sub;
    logic [7:0] dec_query;
    logic [7:0] opc, sub_raw;

    assign strobe  = wr_en && (wr_idx == LAST_IDX);
    assign opc     = cmd_bytes[OPC_IDX];
    assign sub_raw = cmd_bytes[SUB_IDX];

    // Command byte store, written by the host one byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n)     cmd_bytes <= '0;
        else if (wr_en) cmd_bytes[wr_idx] <= wr_data;
    end

    // Opcode and sub-query decode from the stored bytes.
    always_comb begin
        dec_code  = OP_UNKNOWN;
        dec_sub   = '0;
        dec_query = query_lo;
        case (opc)
            8'h00: dec_code = OP_STATUS;
            8'h01: dec_code = OP_STOP;
            8'h02: begin
                if (sub_raw <= SUB_MAX) begin
                    dec_code  = OP_TOC;
                    dec_sub   = sub_raw[SW-1:0];
                    dec_query = sub_raw;
                end else begin
                    dec_code  = OP_STATUS;
                    dec_query = BAD_SUB_QUERY;
                end
            end
            8'h03: dec_code = OP_READ;
            8'h04: dec_code = OP_SEEK;
            8'h06: dec_code = OP_PAUSE;
            8'h07: dec_code = OP_RESUME;
            8'h08: dec_code = OP_FWD;
            8'h09: dec_code = OP_REW;
            8'h0A: dec_code = OP_RESTORE;
            8'h0C: dec_code = OP_CLOSE;
            8'h0D: dec_code = OP_OPEN;
            default: dec_code = OP_UNKNOWN;
        endcase
    end

    // Decode result registers, loaded only on the final-byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            code_q    <= OP_STATUS;
            toc_sub   <= '0;
            query_lo  <= 8'h00;
        end else begin
            cmd_valid <= strobe;
            if (strobe) begin
                code_q   <= dec_code;
                toc_sub  <= dec_sub;
                query_lo <= dec_query;
            end
        end
    end

    assign cmd_code = code_q;

    assert_strobe_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($past(wr_en) && ($past(wr_idx) == LAST_IDX)));
    assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |-> ($stable(cmd_code) && $stable(toc_sub)));
    assert_toc_query_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_TOC) |-> (query_lo == 8'(toc_sub)));
    assert_bad_sub_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_STATUS && query_lo == BAD_SUB_QUERY) |-> (toc_sub == '0));
endmodule

// File: rtl/drv_mailbox.sv
// Top of the drive mailbox: decodes the host byte address into the status
// packet (read only), the command packet, the fader, control and mask bytes,
// and trims the control byte on every status export.
// Map: 0..9 status, 10..19 command, 20/21 fader high/low, 22 control, 23 mask.
module drv_mailbox
    import drv_mbox_pkg::*;
#(
    parameter int AW      = ADDR_W,
    parameter int NBYTES  = PKT_BYTES,
    parameter int IRQ_BIT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          export_req,
    input  logic [7:0]    drv_stat_hi,
    input  logic [15:0]   drv_min,
    input  logic [15:0]   drv_sec,
    input  logic [15:0]   drv_frm,
    input  logic [7:0]    drv_ext,
    output logic          drv_irq,
    output logic          cmd_valid,
    output logic [3:0]    cmd_code,
    output logic [2:0]    toc_sub,
    output logic [15:0]   fader_level,
    output logic [7:0]    drv_ctrl
);
    localparam int IW = $clog2(NBYTES);
    localparam logic [AW-1:0] CMD_BASE = AW'(NBYTES);
    localparam logic [AW-1:0] REG_BASE = AW'(2 * NBYTES);
    localparam logic [AW-1:0] A_FAD_HI = REG_BASE;
    localparam logic [AW-1:0] A_FAD_LO = REG_BASE + AW'(1);
    localparam logic [AW-1:0] A_CTRL   = REG_BASE + AW'(2);
    localparam logic [AW-1:0] A_MASK   = REG_BASE + AW'(3);
    localparam logic [7:0]    CTRL_KEEP = 8'h03;

    logic [NBYTES-1:0][7:0] stat_bytes, cmd_bytes;
    logic [7:0]  query_lo, mask_q;
    logic        in_stat, in_cmd;
    logic [IW-1:0] stat_idx, cmd_idx;

    assign in_stat  = host_addr < CMD_BASE;
    assign in_cmd   = (host_addr >= CMD_BASE) && (host_addr < REG_BASE);
    assign stat_idx = IW'(host_addr);
    assign cmd_idx  = IW'(host_addr - CMD_BASE);

    drv_status_packer #(.NBYTES(NBYTES), .WORD_W(16)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .export_req (export_req),
        .irq_en     (mask_q[IRQ_BIT]),
        .stat_word  ({drv_stat_hi, query_lo}),
        .min_word   (drv_min),
        .sec_word   (drv_sec),
        .frm_word   (drv_frm),
        .ext_byte   (drv_ext),
        .stat_bytes (stat_bytes),
        .irq        (drv_irq)
    );

    drv_cmd_decoder #(.NBYTES(NBYTES), .IW(IW), .SW(3)) u_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (host_we && in_cmd),
        .wr_idx    (cmd_idx),
        .wr_data   (host_wdata),
        .cmd_bytes (cmd_bytes),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .toc_sub   (toc_sub),
        .query_lo  (query_lo)
    );

    // Fader and mask registers, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fader_level <= 16'h0000;
            mask_q      <= 8'h00;
        end else if (host_we) begin
            if (host_addr == A_FAD_HI) fader_level[15:8] <= host_wdata;
            if (host_addr == A_FAD_LO) fader_level[7:0]  <= host_wdata;
            if (host_addr == A_MASK)   mask_q            <= host_wdata;
        end
    end

    // Control register: an export trims it and overrides a host write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  drv_ctrl <= 8'h00;
        else if (export_req)                         drv_ctrl <= drv_ctrl & CTRL_KEEP;
        else if (host_we && host_addr == A_CTRL)     drv_ctrl <= host_wdata;
    end

    // Host read multiplexer.
    always_comb begin
        host_rdata = 8'h00;
        if (in_stat)                    host_rdata = stat_bytes[stat_idx];
        else if (in_cmd)                host_rdata = cmd_bytes[cmd_idx];
        else if (host_addr == A_FAD_HI) host_rdata = fader_level[15:8];
        else if (host_addr == A_FAD_LO) host_rdata = fader_level[7:0];
        else if (host_addr == A_CTRL)   host_rdata = drv_ctrl;
        else if (host_addr == A_MASK)   host_rdata = mask_q;
    end

    assert_ctrl_trim_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(export_req) |-> (drv_ctrl[7:2] == 6'h00));
    assert_valid_irq_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        drv_irq |-> $past(mask_q[IRQ_BIT]));
endmodule

// File: tb/drv_mailbox_bench.sv
// Self-checking bench: directed corners plus seeded random commands and exports.
module drv_mailbox_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_we = 1'b0;
    logic [4:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic export_req = 1'b0;
    logic [7:0] drv_stat_hi = '0;
    logic [15:0] drv_min = '0, drv_sec = '0, drv_frm = '0;
    logic [7:0] drv_ext = '0;
    logic drv_irq, cmd_valid;
    logic [3:0] cmd_code;
    logic [2:0] toc_sub;
    logic [15:0] fader_level;
    logic [7:0] drv_ctrl;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_query = 8'h00;
    logic [3:0] exp_code = 4'h0;
    logic [2:0] exp_sub = 3'h0;
    logic [7:0] cmd_img [10];

    always #4 clk = ~clk;

    drv_mailbox u_drv_mailbox (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .export_req(export_req),
        .drv_stat_hi(drv_stat_hi), .drv_min(drv_min), .drv_sec(drv_sec),
        .drv_frm(drv_frm), .drv_ext(drv_ext), .drv_irq(drv_irq),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .toc_sub(toc_sub),
        .fader_level(fader_level), .drv_ctrl(drv_ctrl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] f_code(input logic [7:0] op, input logic [7:0] sub);
        case (op)
            8'h00, 8'h01, 8'h03, 8'h04, 8'h06, 8'h07, 8'h08, 8'h09,
            8'h0A, 8'h0C, 8'h0D: return op[3:0];
            8'h02: return (sub <= 8'd5) ? 4'h2 : 4'h0;
            default: return 4'hF;
        endcase
    endfunction

    function automatic logic [7:0] f_query(input logic [7:0] op, input logic [7:0] sub,
                                           input logic [7:0] prev);
        if (op != 8'h02) return prev;
        return (sub <= 8'd5) ? sub : 8'h0F;
    endfunction

    function automatic logic [7:0] f_csum(input logic [7:0] b0, b1, b2, b3, b4,
                                          b5, b6, b7, b8);
        logic [7:0] s;
        s = b0 + b1 + b2 + b3 + b4 + b5 + b6 + b7 + b8;
        return {4'h0, ~s[3:0]};
    endfunction

    task automatic host_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic host_wr(input logic [4:0] a, input logic [7:0] d, output logic vld);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        vld = cmd_valid;
        host_we = 1'b0;
    endtask

    // Send a full command packet and check the decode against the model.
    task automatic send_cmd(input logic [7:0] op, input logic [7:0] sub, input logic [7:0] fill);
        logic v;
        for (int i = 0; i < 10; i++) begin
            cmd_img[i] = (i == 0) ? op : (i == 3) ? sub : fill ^ 8'(i);
            host_wr(5'(10 + i), cmd_img[i], v);
        end
        exp_code  = f_code(op, sub);
        exp_sub   = (op == 8'h02 && sub <= 8'd5) ? sub[2:0] : 3'h0;
        exp_query = f_query(op, sub, exp_query);
        chk("R8 cmd_valid pulse", 32'(v), 32'd1);
        chk("R9 cmd_code", 32'(cmd_code), 32'(exp_code));
        chk("R10 toc_sub", 32'(toc_sub), 32'(exp_sub));
        @(negedge clk);
        chk("R8 cmd_valid single cycle", 32'(cmd_valid), 32'd0);
    endtask

    // Export a packet and check every status byte, the checksum and the irq.
    task automatic do_export(input logic [7:0] hi, input logic [15:0] mn, input logic [15:0] sc,
                             input logic [15:0] fr, input logic [7:0] ex, input logic exp_irq);
        logic [7:0] e [10];
        logic [7:0] d;
        @(negedge clk);
        drv_stat_hi = hi; drv_min = mn; drv_sec = sc; drv_frm = fr; drv_ext = ex;
        export_req = 1'b1;
        @(negedge clk);
        export_req = 1'b0;
        chk("R6 irq after export", 32'(drv_irq), 32'(exp_irq));
        e[0] = hi; e[1] = exp_query; e[2] = mn[15:8]; e[3] = mn[7:0];
        e[4] = sc[15:8]; e[5] = sc[7:0]; e[6] = fr[15:8]; e[7] = fr[7:0]; e[8] = ex;
        e[9] = f_csum(e[0], e[1], e[2], e[3], e[4], e[5], e[6], e[7], e[8]);
        for (int i = 0; i < 9; i++) begin
            host_rd(5'(i), d);
            if (i == 0 || i == 1) chk("R4 status word byte", 32'(d), 32'(e[i]));
            else                  chk("R2 packet byte", 32'(d), 32'(e[i]));
        end
        host_rd(5'd9, d);
        chk("R3 checksum", 32'(d), 32'(e[9]));
        chk("R6 irq single cycle", 32'(drv_irq), 32'd0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic v;
        int unsigned seed;
        seed = 32'd1977;
        void'($urandom(seed));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 24; a++) begin
            host_rd(5'(a), d);
            chk("R1 reset byte", 32'(d), (a == 9) ? 32'h0F : 32'h00);
        end
        chk("R1 cmd_valid", 32'(cmd_valid), 32'd0);
        chk("R1 irq", 32'(drv_irq), 32'd0);
        chk("R1 cmd_code", 32'(cmd_code), 32'd0);

        // R7 writes to status area ignored
        host_wr(5'd3, 8'hA5, v);
        host_wr(5'd9, 8'h5A, v);
        host_rd(5'd3, d); chk("R7 status write ignored", 32'(d), 32'h00);
        host_rd(5'd9, d); chk("R7 status write ignored", 32'(d), 32'h0F);

        // R12 fader and unmapped addresses
        host_wr(5'd20, 8'h12, v);
        host_wr(5'd21, 8'h34, v);
        chk("R12 fader", 32'(fader_level), 32'h1234);
        for (int a = 24; a < 32; a++) begin
            host_wr(5'(a), 8'hFF, v);
            host_rd(5'(a), d);
            chk("R12 unmapped reads zero", 32'(d), 32'h00);
        end

        // R6 export with mask clear, then R5 priority with mask set
        do_export(8'h00, 16'h0000, 16'h0000, 16'h0000, 8'h00, 1'b0);
        host_wr(5'd23, 8'h10, v);
        host_wr(5'd22, 8'hFF, v);
        @(negedge clk);
        export_req = 1'b1; host_we = 1'b1; host_addr = 5'd22; host_wdata = 8'hA8;
        @(negedge clk);
        export_req = 1'b0; host_we = 1'b0;
        chk("R5 ctrl trimmed, export wins", 32'(drv_ctrl), 32'h03);
        chk("R6 irq with mask bit 4", 32'(drv_irq), 32'd1);
        host_wr(5'd23, 8'hEF, v);
        do_export(8'h81, 16'hFFFF, 16'h0102, 16'hFE01, 8'hFF, 1'b0);

        // R9 all low opcodes, plus a high one
        for (int op = 0; op < 16; op++) begin
            send_cmd(8'(op), 8'h00, 8'h3C);
        end
        send_cmd(8'h42, 8'h01, 8'h00);
        send_cmd(8'h12, 8'h02, 8'h00);

        // R10 / R11 all sub-queries, checked through the exported status word
        host_wr(5'd23, 8'h10, v);
        for (int s = 0; s < 9; s++) begin
            logic [7:0] sq;
            sq = (s == 8) ? 8'hFF : 8'(s);
            send_cmd(8'h02, sq, 8'h77);
            do_export(8'hC3, 16'h0012, 16'h0034, 16'h0056, 8'h9A, 1'b1);
        end
        // R11 a non-query opcode keeps the query byte
        send_cmd(8'h03, 8'h00, 8'h11);
        do_export(8'h00, 16'h1111, 16'h2222, 16'h3333, 8'h44, 1'b1);

        // R8 hold: a non-final write does not re-decode
        host_wr(5'd10, 8'h0D, v);
        chk("R8 no strobe on byte 0", 32'(v), 32'd0);
        chk("R8 code held", 32'(cmd_code), 32'(exp_code));
        host_rd(5'd10, d);
        chk("R7 command byte readback", 32'(d), 32'h0D);

        // Random mix
        for (int it = 0; it < 150; it++) begin
            logic [7:0] op, sq, ctl;
            logic m;
            op = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 16);
            sq = ($urandom % 3 == 0) ? 8'($urandom) : 8'($urandom % 8);
            send_cmd(op, sq, 8'($urandom));
            begin
                int k;
                k = $urandom % 10;
                host_rd(5'(10 + k), d);
                chk("R7 command byte readback", 32'(d), 32'(cmd_img[k]));
            end
            m = 1'($urandom);
            ctl = 8'($urandom);
            host_wr(5'd23, {3'b000, m, 4'b0000}, v);
            host_wr(5'd22, ctl, v);
            do_export(8'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
                      8'($urandom), m);
            chk("R5 ctrl trimmed", 32'(drv_ctrl), 32'(ctl & 8'h03));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule